// File: doc/BRIEF.md
# PLL Control with Lock Timer

This block is the digital control logic that sits beside a frequency-multiplying PLL. Software programs one 32-bit configuration word through a simple write port and can read it back at any time. The word carries a reference pre-divider setting, a multiplier setting, a lock wait count, a USB divider select and a two-bit output-range setting. The output-range setting is only stored. Everything runs on one system clock. The slow clock, the reference clock and the PLL output clock arrive as single-cycle pulse inputs in that domain.

The pre-divider turns reference pulses into a reference-enable stream. It can be held off, bypassed, or set to divide by 2 to 255. After each configuration write, a lock timer counts slow-clock ticks and then raises a lock flag. Once the flag is up, a power-of-two divider turns the PLL pulses into a USB enable stream. If the reserved USB select code is written, a sticky flag records it.

Top module: `pll_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the read-back word is 0 and lock_o, ref_en, usb_en and cfg_err are all 0.
- R2: Written bits 7:0 (pre-divider), 13:8 (lock count), 15:14 (output range), 26:16 (multiplier) and 29:28 (USB select) read back unchanged on the cycle after the write. Bits 27, 30 and 31 always read 0. The output-range bits change no output.
- R3: With pre-divider value 0, ref_en never pulses.
- R4: With pre-divider value 1, ref_en pulses on the cycle after each ref_pulse.
- R5: With pre-divider value N from 2 to 255, ref_en pulses on the cycle after every N-th ref_pulse. The count starts at the last write, and a write drops any partial count.
- R6: A write clears lock_o on the next cycle and loads the lock count C. With a non-zero multiplier, lock_o rises on the cycle after the (C+1)-th slow_tick that follows the write cycle. A tick in the write cycle itself is not counted. lock_o then stays high until the next write.
- R7: While the multiplier field is 0, lock_o stays 0, the lock timer is idle and usb_en stays 0.
- R8: USB select 0 passes each PLL pulse, select 1 passes every 2nd and select 2 passes every 4th. Pulses are counted only while locked, and usb_en appears one cycle after the PLL pulse that completes a group.
- R9: usb_en pulses only when lock_o was high on the previous cycle. A write cycle produces no usb_en pulse.
- R10: USB select 3 is reserved. It behaves like select 0 and sets cfg_err.
- R11: Once set, cfg_err stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read-back |
| slow_tick | input | 1 | One-cycle slow-clock tick |
| ref_pulse | input | 1 | One-cycle reference clock pulse |
| pll_pulse | input | 1 | One-cycle PLL output pulse |
| ref_en | output | 1 | Pre-divided reference enable |
| usb_en | output | 1 | USB clock enable |
| lock_o | output | 1 | Lock status |
| cfg_err | output | 1 | Sticky reserved-select flag |

## Verification
The assertions take all pulse inputs to be synchronous to clk, each high for whole cycles. They also assume the configuration is changed only through cfg_we, so the read-back word is a true record of what the dividers use. The stimulus drives every input at the falling edge from tasks. It writes a fresh word between traffic windows, and it ends each counted window with idle cycles so that the last pulses have come out before the totals are compared.

// File: rtl/pll_ctrl_pkg.sv
package pll_ctrl_pkg;
    localparam int WORD_W  = 32;
    localparam int DIV_W   = 8;
    localparam int LCK_W   = 6;
    localparam int RNG_W   = 2;
    localparam int MUL_W   = 11;
    localparam int USB_W   = 2;
    localparam int DIV_LSB = 0;
    localparam int LCK_LSB = 8;
    localparam int RNG_LSB = 14;
    localparam int MUL_LSB = 16;
    localparam int USB_LSB = 28;
    localparam int USB_CW  = 2;
    localparam logic [USB_W-1:0] USB_RSVD = '1;

    typedef struct packed {
        logic [USB_W-1:0] usb;
        logic [MUL_W-1:0] mul;
        logic [RNG_W-1:0] rng;
        logic [LCK_W-1:0] lck;
        logic [DIV_W-1:0] div;
    } cfg_t;

    function automatic cfg_t unpack_cfg(input logic [WORD_W-1:0] w);
        cfg_t c;
        c.div = w[DIV_LSB +: DIV_W];
        c.lck = w[LCK_LSB +: LCK_W];
        c.rng = w[RNG_LSB +: RNG_W];
        c.mul = w[MUL_LSB +: MUL_W];
        c.usb = w[USB_LSB +: USB_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_cfg(input cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[DIV_LSB +: DIV_W] = c.div;
        w[LCK_LSB +: LCK_W] = c.lck;
        w[RNG_LSB +: RNG_W] = c.rng;
        w[MUL_LSB +: MUL_W] = c.mul;
        w[USB_LSB +: USB_W] = c.usb;
        return w;
    endfunction
endpackage

// File: rtl/pll_ctrl_refdiv.sv
module pll_ctrl_refdiv #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [DW-1:0] div,
    input  logic          pulse,
    output logic          en
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          en;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = 1'b0;
        if (clr || div == '0) begin
            st_d.cnt = '0;
        end else if (div == DW'(1)) begin
            st_d.cnt = '0;
            st_d.en  = pulse;
        end else if (pulse) begin
            if (st_q.cnt == div - DW'(1)) begin
                st_d.cnt = '0;
                st_d.en  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + DW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en = st_q.en;
endmodule

// File: rtl/pll_ctrl_lock.sv
module pll_ctrl_lock #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          active,
    input  logic          tick,
    output logic          locked
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          locked;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt    = load_val;
            st_d.locked = 1'b0;
        end else if (!active) begin
            st_d.locked = 1'b0;
        end else if (!st_q.locked && tick) begin
            if (st_q.cnt == '0) st_d.locked = 1'b1;
            else                st_d.cnt    = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked = st_q.locked;
endmodule

// File: rtl/pll_ctrl_usbdiv.sv
module pll_ctrl_usbdiv #(
    parameter int SW = 2,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [SW-1:0] sel,
    input  logic          pulse,
    output logic          en
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          en;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] last;

    always_comb begin
        case (sel)
            SW'(1):  last = CW'(1);
            SW'(2):  last = CW'(3);
            default: last = '0;
        endcase
    end

    always_comb begin
        st_d    = st_q;
        st_d.en = 1'b0;
        if (!run) begin
            st_d.cnt = '0;
        end else if (pulse) begin
            if (st_q.cnt == last) begin
                st_d.cnt = '0;
                st_d.en  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en = st_q.en;
endmodule

// File: rtl/pll_ctrl.sv
module pll_ctrl
    import pll_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    input  logic              slow_tick,
    input  logic              ref_pulse,
    input  logic              pll_pulse,
    output logic              ref_en,
    output logic              usb_en,
    output logic              lock_o,
    output logic              cfg_err
);
    typedef struct packed {
        cfg_t cfg;
        logic err;
    } top_t;

    top_t top_d, top_q;
    cfg_t wr_cfg;

    assign wr_cfg = unpack_cfg(cfg_wdata);

    always_comb begin
        top_d = top_q;
        if (cfg_we) begin
            top_d.cfg = wr_cfg;
            if (wr_cfg.usb == USB_RSVD) top_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    pll_ctrl_refdiv #(.DW(DIV_W)) u_refdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_we),
        .div   (top_q.cfg.div),
        .pulse (ref_pulse),
        .en    (ref_en)
    );

    pll_ctrl_lock #(.CW(LCK_W)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_we),
        .load_val (wr_cfg.lck),
        .active   (top_q.cfg.mul != '0),
        .tick     (slow_tick),
        .locked   (lock_o)
    );

    pll_ctrl_usbdiv #(.SW(USB_W), .CW(USB_CW)) u_usbdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (lock_o && !cfg_we),
        .sel   (top_q.cfg.usb),
        .pulse (pll_pulse),
        .en    (usb_en)
    );

    assign cfg_rdata = pack_cfg(top_q.cfg);
    assign cfg_err   = top_q.err;
endmodule

// File: rtl/pll_ctrl_chk.sv
module pll_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [31:0] cfg_rdata,
    input logic        slow_tick,
    input logic        ref_pulse,
    input logic        ref_en,
    input logic        usb_en,
    input logic        lock_o,
    input logic        cfg_err
);
    p_unused_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[31:30] == 2'b00 && cfg_rdata[27] == 1'b0);

    p_off_div_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_en |-> $past(cfg_rdata[7:0]) != 8'd0);

    p_bypass_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[7:0] == 8'd1 && !cfg_we && ref_pulse) |=> ref_en);

    p_write_drops_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !lock_o);

    p_lock_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(slow_tick));

    p_idle_pll_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[26:16] == 11'd0 |-> !lock_o);

    p_usb_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        usb_en |-> $past(lock_o) && !$past(cfg_we));

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
endmodule

bind pll_ctrl pll_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_rdata (cfg_rdata),
    .slow_tick (slow_tick),
    .ref_pulse (ref_pulse),
    .ref_en    (ref_en),
    .usb_en    (usb_en),
    .lock_o    (lock_o),
    .cfg_err   (cfg_err)
);

// File: tb/pll_ctrl_tb.sv
module pll_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        slow_tick = 1'b0;
    logic        ref_pulse = 1'b0;
    logic        pll_pulse = 1'b0;
    logic        ref_en, usb_en, lock_o, cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pll_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .slow_tick(slow_tick), .ref_pulse(ref_pulse),
        .pll_pulse(pll_pulse), .ref_en(ref_en), .usb_en(usb_en),
        .lock_o(lock_o), .cfg_err(cfg_err)
    );

    // behavioural reference model
    logic [31:0] m_reg;
    bit m_lock, m_ref, m_usb, m_err;
    int m_lcnt, m_rcnt, m_ucnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg <= 0; m_lock <= 0; m_ref <= 0; m_usb <= 0; m_err <= 0;
            m_lcnt <= 0; m_rcnt <= 0; m_ucnt <= 0;
        end else begin
            int dv, ratio;
            dv = m_reg[7:0];
            if (cfg_we) begin m_ref <= 0; m_rcnt <= 0; end
            else if (dv == 0) m_ref <= 0;
            else if (dv == 1) m_ref <= ref_pulse;
            else if (ref_pulse) begin
                if (m_rcnt == dv - 1) begin m_ref <= 1; m_rcnt <= 0; end
                else begin m_ref <= 0; m_rcnt <= m_rcnt + 1; end
            end else m_ref <= 0;

            if (cfg_we) begin m_lock <= 0; m_lcnt <= cfg_wdata[13:8]; end
            else if (m_reg[26:16] == 0) m_lock <= 0;
            else if (!m_lock && slow_tick) begin
                if (m_lcnt == 0) m_lock <= 1; else m_lcnt <= m_lcnt - 1;
            end

            ratio = (m_reg[29:28] == 1) ? 2 : (m_reg[29:28] == 2) ? 4 : 1;
            if (cfg_we || !m_lock) begin m_usb <= 0; m_ucnt <= 0; end
            else if (pll_pulse) begin
                if (m_ucnt == ratio - 1) begin m_usb <= 1; m_ucnt <= 0; end
                else begin m_usb <= 0; m_ucnt <= m_ucnt + 1; end
            end else m_usb <= 0;

            if (cfg_we) m_reg <= cfg_wdata & 32'h37FF_FFFF;
            if (cfg_we && cfg_wdata[29:28] == 2'b11) m_err <= 1;
        end
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    int n_ref_en = 0, n_usb_en = 0, n_lock_hi = 0;

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2", "cfg_rdata", cfg_rdata, m_reg);
            check("R5", "ref_en", ref_en, m_ref);
            check("R6", "lock_o", lock_o, m_lock);
            check("R8", "usb_en", usb_en, m_usb);
            check("R11", "cfg_err", cfg_err, m_err);
            n_ref_en += ref_en;
            n_usb_en += usb_en;
            n_lock_hi += lock_o;
        end
    end

    int n_ref_in = 0;

    task automatic step(input bit we, input logic [31:0] wd, input bit rp, input bit pp, input bit tk);
        @(negedge clk);
        cfg_we = we; cfg_wdata = wd; ref_pulse = rp; pll_pulse = pp; slow_tick = tk;
        n_ref_in += rp;
    endtask

    task automatic wr(input logic [31:0] wd);
        step(1'b1, wd, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic traffic(input int n, input int tick_mod);
        for (int i = 0; i < n; i++)
            step(1'b0, 32'h0, $urandom_range(0, 1), $urandom_range(0, 1), ($urandom % tick_mod) == 0);
        step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    endtask

    function automatic logic [31:0] mk(input int dv, input int lck, input int rng, input int mul, input int usb);
        return (32'(usb) << 28) | (32'(mul) << 16) | (32'(rng) << 14) | (32'(lck) << 8) | 32'(dv);
    endfunction

    task automatic zero_counts();
        @(negedge clk);
        n_ref_en = 0; n_usb_en = 0; n_lock_hi = 0; n_ref_in = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "rdata in reset", cfg_rdata, 0);
        check("R1", "outputs in reset", {ref_en, usb_en, lock_o, cfg_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rdata after reset", cfg_rdata, 0);
        check("R1", "outputs after reset", {ref_en, usb_en, lock_o, cfg_err}, 0);

        // R2: unused bits read as zero
        wr(32'hFFFF_FFFF);
        step(0, 0, 0, 0, 0);
        check("R2", "masked readback", cfg_rdata, 32'h37FF_FFFF);

        // R3: divider off
        wr(mk(0, 3, 0, 5, 0));
        zero_counts();
        traffic(200, 4);
        check("R3", "ref_en count with div 0", n_ref_en, 0);

        // R4: bypass
        wr(mk(1, 0, 2, 5, 1));
        zero_counts();
        traffic(200, 3);
        check("R4", "ref_en count with bypass", n_ref_en, n_ref_in);

        // R5: divide by 3 and by 255
        wr(mk(3, 2, 1, 9, 2));
        zero_counts();
        traffic(300, 2);
        check("R5", "ref_en count with div 3", n_ref_en, n_ref_in / 3);
        wr(mk(255, 0, 0, 1, 0));
        zero_counts();
        traffic(1200, 5);
        check("R5", "ref_en count with div 255", n_ref_en, n_ref_in / 255);

        // R6: lock count 4 -> rises after 5th tick following write; tick on write cycle ignored
        step(1, mk(2, 4, 0, 7, 0), 0, 0, 1);
        for (int k = 0; k < 4; k++) begin
            step(0, 0, 0, 0, 1);
            step(0, 0, 0, 0, 0);
        end
        step(0, 0, 0, 0, 0);
        check("R6", "not locked after 4 ticks", lock_o, 0);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0);
        check("R6", "locked after 5th tick", lock_o, 1);
        wr(mk(2, 4, 0, 7, 0));
        step(0, 0, 0, 0, 0);
        check("R6", "write clears lock", lock_o, 0);

        // R7: multiplier 0 keeps lock and usb off
        wr(mk(1, 0, 3, 0, 0));
        zero_counts();
        traffic(200, 1);
        check("R7", "lock with mul 0", n_lock_hi, 0);
        check("R7", "usb with mul 0", n_usb_en, 0);

        // R9: no usb before lock (long wait count)
        wr(mk(1, 63, 0, 3, 0));
        zero_counts();
        traffic(50, 4);
        check("R9", "usb before lock", n_usb_en, 0);

        // R8: each select with traffic, model compared every cycle
        wr(mk(4, 1, 0, 100, 0)); traffic(150, 3);
        wr(mk(4, 0, 0, 100, 1)); traffic(150, 3);
        wr(mk(4, 5, 1, 2047, 2)); traffic(300, 2);
        check("R8", "usb pulses seen", n_usb_en > 0, 1);

        // R10/R11: reserved select
        wr(mk(2, 0, 0, 20, 3));
        traffic(150, 2);
        check("R10", "cfg_err after reserved", cfg_err, 1);
        wr(mk(2, 0, 0, 20, 0));
        traffic(20, 2);
        check("R11", "cfg_err sticky", cfg_err, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule